// File: doc/BRIEF.md
# Priority Reference Selector with Override

This block picks which of several candidate reference clocks steers the main timing loop. Each candidate carries a valid flag, supplied by measurement logic elsewhere, and a programmable priority. An automatic ranking finds the three best eligible candidates on every cycle. The selected-reference index for the main loop normally follows that ranking, either revertively or non-revertively.

Two overrides act on the main loop's choice. In forced mode, one nominated candidate is preferred whenever it is eligible, and the revert setting still decides when the choice moves. In external mode, the block acts as a plain clock switch. The main index takes the externally commanded number even when that candidate is invalid, and the revert setting is ignored. In every mode the ranking outputs keep reporting the automatic result. An optional secondary selector, for an auxiliary loop, always behaves automatically.

Candidates are numbered from 1 upward on every index port, and the value 0 means "none". All outputs are registered on the system clock.

Top module: `ref_priority_selector`

## Requirements
- R1: `rank1`, `rank2` and `rank3` give the numbers (1..N) of the first, second and third eligible candidates. The order is ascending priority value, and equal values go to the lower candidate number. Slots with no candidate read 0. Each result appears after the rising edge that samples the inputs.
- R2: A candidate is eligible only when its valid bit is 1 and its 4-bit priority field (bits [4i+3:4i] of `ref_prio` for candidate i+1) is nonzero. A priority of 0 excludes the candidate even when it is valid.
- R3: When `sel_mode` is 2'b10 (external), `main_sel` equals `ext_num` after the next rising edge. This holds for any value of `ext_num`, including an ineligible candidate or 0, and for either value of `revert_en`.
- R4: In external mode the ranking outputs and `no_ref` keep following the automatic ranking.
- R5: In automatic mode (`sel_mode` 2'b00) with `revert_en`=1, `main_sel` takes the `rank1` result on each edge at which some candidate is eligible.
- R6: In automatic mode with `revert_en`=0, `main_sel` keeps its value while that candidate stays eligible. When the held candidate is ineligible (or the index is 0), `main_sel` moves to the top-ranked candidate.
- R7: In forced mode (`sel_mode` 2'b01), the preferred target is `force_num` when that candidate is eligible, and otherwise the top-ranked candidate. The rules of R5 and R6 are then applied to that target according to `revert_en`.
- R8: When no candidate is eligible, `no_ref` is 1 and all three ranking outputs read 0. Outside external mode, `main_sel` and `aux_sel` hold their previous values.
- R9: During reset all index outputs read 0 and `no_ref` reads 1.
- R10: `sel_mode` 2'b11 behaves exactly as automatic mode.
- R11: `aux_sel` follows the automatic rules of R5, R6 and R8 using `revert_en`, and ignores `sel_mode`, `force_num` and `ext_num`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | N_REFS | Per-candidate valid flags, bit i is candidate i+1 |
| ref_prio | input | N_REFS*PRIO_W | Packed priorities, lower nonzero value wins, 0 disables |
| sel_mode | input | 2 | 00 automatic, 01 forced, 10 external, 11 automatic |
| revert_en | input | 1 | 1 selects revertive behaviour |
| force_num | input | IDX_W | Preferred candidate in forced mode |
| ext_num | input | IDX_W | Commanded candidate in external mode |
| rank1 | output | IDX_W | Best eligible candidate, 0 when none |
| rank2 | output | IDX_W | Second-best eligible candidate, 0 when none |
| rank3 | output | IDX_W | Third-best eligible candidate, 0 when none |
| main_sel | output | IDX_W | Selected reference of the main loop |
| aux_sel | output | IDX_W | Selected reference of the auxiliary loop |
| no_ref | output | 1 | No candidate eligible |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. The ranking outputs, `no_ref`, `main_sel` and `aux_sel` are all registered from the inputs sampled at that edge, together with the previous selection. The bench changes inputs on a falling edge, lets exactly one rising edge pass, and compares all six outputs on the following falling edge. It compares them against a reference model that it advances at that same rising edge. The sweep walks every valid-flag mask under several priority sets that contain ties and zeros. Along the way it rotates the mode, the revert setting and the override numbers, including numbers of 0 and numbers above the candidate count.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   typedef enum logic [1:0] {
      MODE_AUTO     = 2'b00,
      MODE_FORCE    = 2'b01,
      MODE_EXT      = 2'b10,
      MODE_AUTO_ALT = 2'b11
   } sel_mode_e;

   localparam int unsigned RANK_SLOTS = 3;
endpackage

// File: rtl/refsel_rank.sv
module refsel_rank #(
   parameter int unsigned N_REFS = 8,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = $clog2(N_REFS + 1)
) (
   input  logic [N_REFS-1:0]        elig,
   input  logic [N_REFS*PRIO_W-1:0] prio_flat,
   output logic [2:0][IDX_W-1:0]    top
);
   localparam int unsigned PL_W = $clog2(N_REFS + 1);

   logic [PRIO_W-1:0] pr    [N_REFS];
   logic [N_REFS-1:0] beats [N_REFS];
   logic [PL_W-1:0]   place [N_REFS];

   for (genvar g = 0; g < N_REFS; g++) begin : g_unpack
      assign pr[g] = prio_flat[g*PRIO_W +: PRIO_W];
   end

   // beats[i][j]: candidate j ranks ahead of candidate i
   always_comb begin
      for (int i = 0; i < N_REFS; i++) begin
         for (int j = 0; j < N_REFS; j++) begin
            beats[i][j] = elig[j] && ((pr[j] < pr[i]) || ((pr[j] == pr[i]) && (j < i)));
         end
         place[i] = PL_W'($countones(beats[i]));
      end
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < N_REFS; i++) begin
         for (int k = 0; k < 3; k++) begin
            if (elig[i] && (place[i] == PL_W'(k))) top[k] = IDX_W'(i + 1);
         end
      end
   end
endmodule

// File: rtl/refsel_track.sv
module refsel_track #(
   parameter int unsigned N_REFS = 8,
   parameter int unsigned IDX_W  = $clog2(N_REFS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REFS-1:0] elig,
   input  logic [IDX_W-1:0]  target,
   input  logic              revert_en,
   input  logic              override_en,
   input  logic [IDX_W-1:0]  override_num,
   output logic [IDX_W-1:0]  sel_q
);
   logic             cur_ok;
   logic [IDX_W-1:0] sel_d;

   always_comb begin
      cur_ok = 1'b0;
      for (int i = 0; i < N_REFS; i++) begin
         if ((sel_q == IDX_W'(i + 1)) && elig[i]) cur_ok = 1'b1;
      end
   end

   always_comb begin
      if (override_en)              sel_d = override_num;
      else if (target == '0)        sel_d = sel_q;
      else if (revert_en || !cur_ok) sel_d = target;
      else                          sel_d = sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_d;
   end
endmodule

// File: rtl/ref_priority_selector.sv
module ref_priority_selector #(
   parameter int unsigned N_REFS   = 8,
   parameter int unsigned PRIO_W   = 4,
   parameter bit          AUX_PATH = 1'b1,
   parameter int unsigned IDX_W    = $clog2(N_REFS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_REFS-1:0]        ref_valid,
   input  logic [N_REFS*PRIO_W-1:0] ref_prio,
   input  logic [1:0]               sel_mode,
   input  logic                     revert_en,
   input  logic [IDX_W-1:0]         force_num,
   input  logic [IDX_W-1:0]         ext_num,
   output logic [IDX_W-1:0]         rank1,
   output logic [IDX_W-1:0]         rank2,
   output logic [IDX_W-1:0]         rank3,
   output logic [IDX_W-1:0]         main_sel,
   output logic [IDX_W-1:0]         aux_sel,
   output logic                     no_ref
);
   import refsel_pkg::*;

   if (N_REFS < refsel_pkg::RANK_SLOTS) begin : g_chk_n
      $error("N_REFS must be at least the number of rank slots");
   end
   if (PRIO_W < 1) begin : g_chk_pw
      $error("PRIO_W must be at least 1");
   end
   if (IDX_W < $clog2(N_REFS + 1)) begin : g_chk_iw
      $error("IDX_W too narrow for candidate numbers");
   end

   sel_mode_e                 mode;
   logic [N_REFS-1:0]         elig;
   logic [2:0][IDX_W-1:0]     top;
   logic                      force_ok;
   logic [IDX_W-1:0]          main_target;

   assign mode = sel_mode_e'(sel_mode);

   for (genvar g = 0; g < N_REFS; g++) begin : g_elig
      assign elig[g] = ref_valid[g] && (ref_prio[g*PRIO_W +: PRIO_W] != '0);
   end

   refsel_rank #(.N_REFS(N_REFS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
      .elig      (elig),
      .prio_flat (ref_prio),
      .top       (top)
   );

   always_comb begin
      force_ok = 1'b0;
      for (int i = 0; i < N_REFS; i++) begin
         if ((force_num == IDX_W'(i + 1)) && elig[i]) force_ok = 1'b1;
      end
      main_target = ((mode == MODE_FORCE) && force_ok) ? force_num : top[0];
   end

   refsel_track #(.N_REFS(N_REFS), .IDX_W(IDX_W)) u_main (
      .clk          (clk),
      .rst_n        (rst_n),
      .elig         (elig),
      .target       (main_target),
      .revert_en    (revert_en),
      .override_en  (mode == MODE_EXT),
      .override_num (ext_num),
      .sel_q        (main_sel)
   );

   if (AUX_PATH) begin : g_aux
      refsel_track #(.N_REFS(N_REFS), .IDX_W(IDX_W)) u_aux (
         .clk          (clk),
         .rst_n        (rst_n),
         .elig         (elig),
         .target       (top[0]),
         .revert_en    (revert_en),
         .override_en  (1'b0),
         .override_num ('0),
         .sel_q        (aux_sel)
      );
   end else begin : g_no_aux
      assign aux_sel = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rank1  <= '0;
         rank2  <= '0;
         rank3  <= '0;
         no_ref <= 1'b1;
      end else begin
         rank1  <= top[0];
         rank2  <= top[1];
         rank3  <= top[2];
         no_ref <= (elig == '0);
      end
   end
endmodule

// File: rtl/refsel_checks.sv
module refsel_checks #(
   parameter int unsigned N_REFS   = 8,
   parameter int unsigned PRIO_W   = 4,
   parameter bit          AUX_PATH = 1'b1,
   parameter int unsigned IDX_W    = $clog2(N_REFS + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_REFS-1:0]        ref_valid,
   input logic [N_REFS*PRIO_W-1:0] ref_prio,
   input logic [1:0]               sel_mode,
   input logic                     revert_en,
   input logic [IDX_W-1:0]         force_num,
   input logic [IDX_W-1:0]         ext_num,
   input logic [IDX_W-1:0]         rank1,
   input logic [IDX_W-1:0]         rank2,
   input logic [IDX_W-1:0]         rank3,
   input logic [IDX_W-1:0]         main_sel,
   input logic [IDX_W-1:0]         aux_sel,
   input logic                     no_ref
);
   logic any_ok, main_ok, aux_ok;

   always_comb begin
      any_ok  = 1'b0;
      main_ok = 1'b0;
      aux_ok  = 1'b0;
      for (int i = 0; i < N_REFS; i++) begin
         if (ref_valid[i] && (ref_prio[i*PRIO_W +: PRIO_W] != '0)) begin
            any_ok = 1'b1;
            if (main_sel == IDX_W'(i + 1)) main_ok = 1'b1;
            if (aux_sel == IDX_W'(i + 1))  aux_ok  = 1'b1;
         end
      end
   end

   assert_ext_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_mode == 2'b10) |=> (main_sel == $past(ext_num)));

   assert_rank_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rank2 != '0) |-> ((rank1 != '0) && (rank1 != rank2)));

   assert_rank_third_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rank3 != '0) |-> ((rank2 != '0) && (rank3 != rank2) && (rank3 != rank1)));

   assert_noref_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      no_ref == (rank1 == '0));

   assert_noref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ok && (sel_mode != 2'b10)) |=> $stable(main_sel));

   assert_rev_best_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_mode == 2'b00) && revert_en && any_ok) |=> (main_sel == rank1));

   assert_nonrev_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_mode == 2'b00) && !revert_en && main_ok) |=> $stable(main_sel));

   assert_aux_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (AUX_PATH && !revert_en && aux_ok) |=> $stable(aux_sel));
endmodule

bind ref_priority_selector refsel_checks #(
   .N_REFS(N_REFS), .PRIO_W(PRIO_W), .AUX_PATH(AUX_PATH), .IDX_W(IDX_W)
) u_refsel_checks (.*);

// File: tb/test_ref_priority_selector.sv
module test_ref_priority_selector;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int PW = 4;
   localparam int IW = $clog2(N + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    ref_valid = '0;
   logic [N*PW-1:0] ref_prio = '0;
   logic [1:0]      sel_mode = 2'b00;
   logic            revert_en = 1'b0;
   logic [IW-1:0]   force_num = '0;
   logic [IW-1:0]   ext_num = '0;
   logic [IW-1:0]   rank1, rank2, rank3, main_sel, aux_sel;
   logic            no_ref;

   int total = 0;
   int bad = 0;
   int m_main = 0, m_aux = 0;
   int e_rank [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   ref_priority_selector #(.N_REFS(N), .PRIO_W(PW)) i_ref_priority_selector (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_prio(ref_prio),
      .sel_mode(sel_mode), .revert_en(revert_en), .force_num(force_num),
      .ext_num(ext_num), .rank1(rank1), .rank2(rank2), .rank3(rank3),
      .main_sel(main_sel), .aux_sel(aux_sel), .no_ref(no_ref)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit ok(input int n);
      if (n < 1 || n > N) return 1'b0;
      return ref_valid[n-1] && (ref_prio[(n-1)*PW +: PW] != 0);
   endfunction

   function automatic int pr(input int n);
      return int'(ref_prio[(n-1)*PW +: PW]);
   endfunction

   // selection sort by repeated minimum search
   task automatic model_rank();
      for (int k = 0; k < 3; k++) begin
         int best = 0;
         for (int n = 1; n <= N; n++) begin
            bit used = 1'b0;
            for (int q = 0; q < k; q++) if (e_rank[q] == n) used = 1'b1;
            if (ok(n) && !used && (best == 0 || pr(n) < pr(best))) best = n;
         end
         e_rank[k] = best;
      end
   endtask

   function automatic int next_sel(input int cur, input int tgt);
      if (tgt == 0) return cur;
      if (revert_en || !ok(cur)) return tgt;
      return cur;
   endfunction

   // one rising edge, model update, check at the following falling edge
   task automatic step();
      int tgt;
      @(posedge clk);
      model_rank();
      tgt = e_rank[0];
      if (sel_mode == 2'b01 && ok(int'(force_num))) tgt = int'(force_num);
      if (sel_mode == 2'b10) m_main = int'(ext_num);
      else m_main = next_sel(m_main, tgt);
      m_aux = next_sel(m_aux, e_rank[0]);
      @(negedge clk);
      begin
         string rt;
         string mt;
         rt = (sel_mode == 2'b10) ? "R4 rank" : "R1 rank";
         chk({rt, "1"}, int'(rank1), e_rank[0]);
         chk({rt, "2"}, int'(rank2), e_rank[1]);
         chk({rt, "3"}, int'(rank3), e_rank[2]);
         chk("R8 no_ref", int'(no_ref), (e_rank[0] == 0) ? 1 : 0);
         case (sel_mode)
            2'b00: mt = revert_en ? "R5 main_sel" : "R6 main_sel";
            2'b01: mt = "R7 main_sel";
            2'b10: mt = "R3 main_sel";
            default: mt = "R10 main_sel";
         endcase
         chk(mt, int'(main_sel), m_main);
         chk("R11 aux_sel", int'(aux_sel), m_aux);
      end
   endtask

   task automatic set_prio(input int n, input int v);
      ref_prio[(n-1)*PW +: PW] = PW'(v);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 rank1", int'(rank1), 0);
      chk("R9 main_sel", int'(main_sel), 0);
      chk("R9 aux_sel", int'(aux_sel), 0);
      chk("R9 no_ref", int'(no_ref), 1);
      rst_n = 1'b1;

      // R1: equal priorities, ties to lower number
      ref_valid = '1;
      for (int n = 1; n <= N; n++) set_prio(n, 5);
      revert_en = 1'b1;
      step();
      chk("R1 tie rank1", int'(rank1), 1);
      chk("R1 tie rank3", int'(rank3), 3);

      // R2: priority 0 excludes a valid input
      set_prio(1, 0);
      step();
      chk("R2 excluded rank1", int'(rank1), 2);

      // R3: external mode commands an ineligible input
      ref_valid = '0;
      sel_mode = 2'b10;
      ext_num = IW'(6);
      step();
      chk("R3 ext invalid", int'(main_sel), 6);
      chk("R8 no_ref ext", int'(no_ref), 1);
      sel_mode = 2'b00;
      step();
      chk("R8 hold main", int'(main_sel), 6);

      // sweep: every valid mask under rotating priority sets and controls
      for (int it = 0; it < 2048; it++) begin
         ref_valid = N'(it);
         for (int n = 1; n <= N; n++) set_prio(n, ((n - 1) * 3 + (it >> 8) * 5) % 9);
         sel_mode  = 2'((it >> 3) & 3);
         revert_en = 1'((it >> 5) & 1);
         force_num = IW'((it >> 4) % 10);
         ext_num   = IW'((it * 7) % 16);
         step();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule